// File: doc/BRIEF.md
# Dual Down-Counter Timer Window

This block places two independent prescaled down-counter timers behind one 4 KB register window. The low 12 bits of a byte address select the target. The first 32 bytes belong to timer A. The next 32 bytes belong to timer B, which sees the address with 0x20 removed. The top 32 bytes of the window return a fixed eight-byte identification table. Every other location reads as zero, and that includes the two test locations at 0xF00 and 0xF04. The interrupts of the two timers are merged into one output.

Each timer has its own tick-enable input, so the two can count at unrelated rates. Each timer also has a programmable prescaler, a 16-bit or 32-bit count width, and three counting modes: free-running, periodic reload and one-shot. Each timer is built around a three-state machine:

- `TMR_IDLE`: disabled.
- `TMR_COUNT`: counting.
- `TMR_SPENT`: a one-shot run has expired and the timer is parked.

The transitions are:

- `go`: a control write with enable set, from any state, leads to `TMR_COUNT`.
- `halt`: a control write with enable clear leads to `TMR_IDLE`.
- `fire_once`: an expiry in one-shot mode leads from `TMR_COUNT` to `TMR_SPENT`.

A control write takes priority over an expiry in the same cycle.

Top module: `dual_timer_window`

## Requirements
- R1: Address bits above bit 11 are ignored. Offsets 0x00-0x1F reach timer A and offsets 0x20-0x3F reach timer B, with local offset = offset - 0x20. Offset bits 1:0 are ignored.
- R2: The local register layout is as follows. 0x00 LOAD: a write sets both limit and count, and a read returns the limit. 0x04 COUNT: read-only, and writes are ignored. 0x08 CTRL. 0x0C ACK: a write clears the raw flag, and a read returns 0. 0x10 RAW flag. 0x14 MASKED flag. 0x18 SHADOW: a write sets the limit only, and a read returns the limit. 0x1C reads as 0.
- R3: CTRL holds 8 bits and reads back zero-extended. The bits are:
  - bit0: one-shot.
  - bit1: 32-bit width (0 selects 16-bit).
  - bits3:2: prescale. 00 and 11 give /1, 01 gives /16, 10 gives /256.
  - bit5: interrupt enable.
  - bit6: periodic.
  - bit7: enable.

  The reset value is 0x20. A CTRL write restarts the prescaler.
- R4: While counting, each prescaled tick decrements the count. A tick that finds the count zero is an expiry; in 16-bit width only bits 15:0 are tested. An expiry sets RAW and reloads the count as follows. One-shot (bit0) reloads 0. Periodic (bit6, with bit0 clear) reloads the limit, masked to 16 bits in 16-bit width. Free-running reloads 0xFFFF or 0xFFFFFFFF. A LOAD write takes precedence over a tick in the same cycle, and that tick is dropped.
- R5: After a one-shot expiry the count holds until a CTRL write.
- R6: `irq` is high when either timer has RAW=1 and CTRL bit5=1. It stays high until both timers are cleared or masked. MASKED reads RAW AND bit5.
- R7: Offsets 0xFE0-0xFFC read the bytes 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, one per word in that order, zero-extended. Writes there have no effect.
- R8: Reads of all other offsets, including 0xF00 and 0xF04, return 0. Writes at or above 0x40 change nothing.
- R9: Timer A advances only on `tick_en[0]`, and timer B advances only on `tick_en[1]`.
- R10: Read data appears on `rdata` in the cycle after the read request and holds until the next read.
- R11: An ACK write that coincides with an expiry leaves RAW set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request for this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Byte address; only bits 11:0 decode |
| wdata | input | 32 | Write data |
| tick_en | input | 2 | Per-timer count enables (bit 0 = A, bit 1 = B) |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Merged interrupt |

## Verification
Timer A is run periodic at full rate, and then free-running in 16-bit width behind the /256 prescaler with nonzero upper count bits. Together these separate the width masking from the reload choice. Timer B is run one-shot at /16, first with its own tick held low while A counts, which shows that the tick inputs are separate and that the park state holds. The interrupt merge is tried with both timers pending and then cleared one at a time, and with interrupt enable clear while RAW is set. An ACK is placed exactly on an expiry cycle to test the set-over-clear rule. A behavioural model is stepped every clock and compared against `irq` and all read data.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
    typedef enum logic [1:0] {
        TMR_IDLE  = 2'd0,
        TMR_COUNT = 2'd1,
        TMR_SPENT = 2'd2
    } tmr_state_e;

    localparam int CTRL_W = 8;
    localparam int ID_W   = 8;

    // local register word index (offset bits 4:2)
    localparam logic [2:0] REG_LOAD   = 3'd0;
    localparam logic [2:0] REG_COUNT  = 3'd1;
    localparam logic [2:0] REG_CTRL   = 3'd2;
    localparam logic [2:0] REG_ACK    = 3'd3;
    localparam logic [2:0] REG_RAW    = 3'd4;
    localparam logic [2:0] REG_MASKED = 3'd5;
    localparam logic [2:0] REG_SHADOW = 3'd6;

    // control bit positions
    localparam int CB_ONESHOT  = 0;
    localparam int CB_WIDE     = 1;
    localparam int CB_PRE_LO   = 2;
    localparam int CB_IE       = 5;
    localparam int CB_PERIODIC = 6;
    localparam int CB_EN       = 7;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;
endpackage

// File: rtl/dtw_prescaler.sv
module dtw_prescaler #(
    parameter int PRE_W     = 8,
    parameter int MID_SHIFT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       run,
    input  logic       tick_en,
    input  logic [1:0] div_sel,
    output logic       tick
);
    localparam logic [PRE_W-1:0] MID_LAST  = PRE_W'((1 << MID_SHIFT) - 1);
    localparam logic [PRE_W-1:0] FULL_LAST = {PRE_W{1'b1}};

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] last;

    always_comb begin
        unique case (div_sel)
            2'b01:   last = MID_LAST;
            2'b10:   last = FULL_LAST;
            default: last = '0;
        endcase
    end

    assign tick = run && tick_en && (pre_cnt == last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (clear) begin
            pre_cnt <= '0;
        end else if (run && tick_en) begin
            pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
        end
    end

    // R3
    prescale_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pre_cnt == '0));
endmodule

// File: rtl/dtw_timer.sv
module dtw_timer
    import dtw_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NARROW_W  = 16,
    parameter int PRE_W     = 8,
    parameter int MID_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        reg_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam logic [DATA_W-1:0] NARROW_MASK =
        {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    tmr_state_e         state, state_nx;
    logic [CTRL_W-1:0]  ctrl;
    logic [DATA_W-1:0]  limit;
    logic [DATA_W-1:0]  count;
    logic [DATA_W-1:0]  reload;
    logic               ris;

    logic do_load, do_ctrl, do_ack, do_shadow;
    logic tick, step, at_zero, expire;
    logic wide, one_shot, periodic;

    assign do_load   = wr_en && (reg_idx == REG_LOAD);
    assign do_ctrl   = wr_en && (reg_idx == REG_CTRL);
    assign do_ack    = wr_en && (reg_idx == REG_ACK);
    assign do_shadow = wr_en && (reg_idx == REG_SHADOW);

    assign wide     = ctrl[CB_WIDE];
    assign one_shot = ctrl[CB_ONESHOT];
    assign periodic = ctrl[CB_PERIODIC];

    dtw_prescaler #(
        .PRE_W    (PRE_W),
        .MID_SHIFT(MID_SHIFT)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (do_ctrl),
        .run    (state == TMR_COUNT),
        .tick_en(tick_en),
        .div_sel(ctrl[CB_PRE_LO+1:CB_PRE_LO]),
        .tick   (tick)
    );

    assign at_zero = wide ? (count == '0) : (count[NARROW_W-1:0] == '0);
    assign step    = tick && !do_load;
    assign expire  = step && at_zero;

    always_comb begin
        if (one_shot)      reload = '0;
        else if (periodic) reload = wide ? limit : (limit & NARROW_MASK);
        else               reload = wide ? {DATA_W{1'b1}} : NARROW_MASK;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            TMR_IDLE: begin
                if (do_ctrl && wdata[CB_EN]) state_nx = TMR_COUNT;     // go
            end
            TMR_COUNT: begin
                if (do_ctrl)                 state_nx = wdata[CB_EN] ? TMR_COUNT : TMR_IDLE;
                else if (expire && one_shot) state_nx = TMR_SPENT;     // fire_once
            end
            TMR_SPENT: begin
                if (do_ctrl)                 state_nx = wdata[CB_EN] ? TMR_COUNT : TMR_IDLE;
            end
            default:                         state_nx = TMR_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TMR_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= CTRL_RESET;
            limit <= '0;
            count <= '0;
            ris   <= 1'b0;
        end else begin
            if (do_ctrl)              ctrl  <= wdata[CTRL_W-1:0];
            if (do_load || do_shadow) limit <= wdata;
            if (do_load)              count <= wdata;
            else if (step)            count <= at_zero ? reload : count - 1'b1;
            if (expire)               ris   <= 1'b1;
            else if (do_ack)          ris   <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_idx)
            REG_LOAD, REG_SHADOW: rd_data = limit;
            REG_COUNT:            rd_data = count;
            REG_CTRL:             rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
            REG_RAW:              rd_data = {{(DATA_W-1){1'b0}}, ris};
            REG_MASKED:           rd_data = {{(DATA_W-1){1'b0}}, ris & ctrl[CB_IE]};
            default:              rd_data = '0;
        endcase
    end

    assign irq = ris & ctrl[CB_IE];

    // R4
    raw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ris) |-> ($past(state) == TMR_COUNT));

    // R5
    spent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TMR_SPENT && !wr_en) |=> $stable(count));

    // R2
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ack && state != TMR_COUNT) |=> !ris);

    // R3
    idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TMR_IDLE && !wr_en) |=> ($stable(count) && $stable(ris)));
endmodule

// File: rtl/dtw_id_rom.sv
module dtw_id_rom
    import dtw_pkg::*;
(
    input  logic [2:0]      idx,
    output logic [ID_W-1:0] id_byte
);
    always_comb begin
        unique case (idx)
            3'd0: id_byte = 8'h04;
            3'd1: id_byte = 8'h18;
            3'd2: id_byte = 8'h14;
            3'd3: id_byte = 8'h00;
            3'd4: id_byte = 8'h0D;
            3'd5: id_byte = 8'hF0;
            3'd6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    end
endmodule

// File: rtl/dual_timer_window.sv
module dual_timer_window
    import dtw_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int N_TIMERS  = 2,
    parameter int WIN_W     = 12,
    parameter int SLOT_W    = 5,
    parameter int NARROW_W  = 16,
    parameter int PRE_W     = 8,
    parameter int MID_SHIFT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [N_TIMERS-1:0] tick_en,
    output logic [DATA_W-1:0]   rdata,
    output logic                irq
);
    localparam int SEL_W = WIN_W - SLOT_W;

    logic [WIN_W-1:0]  off;
    logic [SEL_W-1:0]  slot;
    logic [2:0]        reg_idx;
    logic              in_timers, id_hit;
    logic [ID_W-1:0]   id_byte;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] t_rd [N_TIMERS];
    logic [N_TIMERS-1:0] t_irq;
    logic              unused_addr_hi;

    assign off            = addr[WIN_W-1:0];
    assign unused_addr_hi = ^addr[ADDR_W-1:WIN_W];
    assign slot           = off[WIN_W-1:SLOT_W];
    assign reg_idx        = off[SLOT_W-1:2];
    assign in_timers      = (slot < SEL_W'(N_TIMERS));
    assign id_hit         = &slot;

    for (genvar k = 0; k < N_TIMERS; k++) begin : g_tmr
        logic slot_wr;
        assign slot_wr = req && wr && (slot == SEL_W'(k));

        dtw_timer #(
            .DATA_W   (DATA_W),
            .NARROW_W (NARROW_W),
            .PRE_W    (PRE_W),
            .MID_SHIFT(MID_SHIFT)
        ) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (slot_wr),
            .reg_idx(reg_idx),
            .wdata  (wdata),
            .tick_en(tick_en[k]),
            .rd_data(t_rd[k]),
            .irq    (t_irq[k])
        );
    end

    dtw_id_rom u_id (
        .idx    (reg_idx),
        .id_byte(id_byte)
    );

    always_comb begin
        rd_mux = '0;
        if (in_timers) begin
            for (int k = 0; k < N_TIMERS; k++) begin
                if (slot == SEL_W'(k)) rd_mux = t_rd[k];
            end
        end else if (id_hit) begin
            rd_mux = {{(DATA_W-ID_W){1'b0}}, id_byte};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        rdata <= '0;
        else if (req && !wr) rdata <= rd_mux;
    end

    assign irq = |t_irq;

    // R7
    id_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr && id_hit) |=> (rdata[DATA_W-1:ID_W] == '0));

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr && !in_timers && !id_hit) |=> (rdata == '0));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && !wr) |=> $stable(rdata));
endmodule

// File: tb/sim_dual_timer_window.sv
module sim_dual_timer_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, wr = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [1:0]  tk = '0;
    logic [31:0] rdata;
    logic        irq;

    always #10 clk = ~clk;

    dual_timer_window u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .wdata(wdata), .tick_en(tk), .rdata(rdata), .irq(irq)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    // behavioural reference state
    logic [31:0] m_cnt [2];
    logic [31:0] m_lim [2];
    logic [7:0]  m_ctl [2];
    bit          m_ris [2];
    int          m_st  [2];   // 0 idle, 1 counting, 2 parked
    int          m_pre [2];
    bit          rd_pend = 0;
    logic [31:0] exp_rd;
    string       cur_tag = "", pend_tag = "";

    function automatic logic [7:0] id_val(int i);
        logic [7:0] t [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        return t[i];
    endfunction

    function automatic logic [31:0] m_read(logic [15:0] a);
        int o = int'(a[11:0]);
        int t, r;
        if (o >= 12'hFE0) return {24'h0, id_val((o - 12'hFE0) / 4)};
        if (o >= 12'h40) return 32'h0;
        t = o / 32;
        r = (o % 32) / 4;
        case (r)
            0, 6: return m_lim[t];
            1:    return m_cnt[t];
            2:    return {24'h0, m_ctl[t]};
            4:    return {31'h0, m_ris[t]};
            5:    return {31'h0, m_ris[t] & m_ctl[t][5]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_step(int k, bit wnow, logic [15:0] a, logic [31:0] d, bit tin);
        int  o   = int'(a[11:0]);
        bit  hit = wnow && (o < 64) && (o / 32 == k);
        int  r   = (o % 32) / 4;
        bit  ld  = hit && r == 0;
        bit  ct  = hit && r == 2;
        bit  ak  = hit && r == 3;
        bit  sh  = hit && r == 6;
        int  psel = int'(m_ctl[k][3:2]);
        int  dv  = (psel == 1) ? 16 : (psel == 2) ? 256 : 1;
        bit  run = (m_st[k] == 1);
        bit  tck = run && tin && (m_pre[k] == dv - 1);
        bit  wide = m_ctl[k][1];
        bit  zero = wide ? (m_cnt[k] == 0) : (m_cnt[k][15:0] == 0);
        bit  fire = tck && zero && !ld;
        logic [31:0] rl;
        if (m_ctl[k][0])      rl = 0;
        else if (m_ctl[k][6]) rl = wide ? m_lim[k] : (m_lim[k] & 32'hFFFF);
        else                  rl = wide ? 32'hFFFF_FFFF : 32'hFFFF;
        if (ct)               m_pre[k] = 0;
        else if (run && tin)  m_pre[k] = tck ? 0 : m_pre[k] + 1;
        if (ld)               m_cnt[k] = d;
        else if (tck)         m_cnt[k] = zero ? rl : m_cnt[k] - 1;
        if (fire)             m_ris[k] = 1;
        else if (ak)          m_ris[k] = 0;
        if (ct)               m_st[k] = d[7] ? 1 : 0;
        else if (fire && m_ctl[k][0]) m_st[k] = 2;
        if (ct)               m_ctl[k] = d[7:0];
        if (ld || sh)         m_lim[k] = d;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_cnt[k] = 0; m_lim[k] = 0; m_ctl[k] = 8'h20;
                m_ris[k] = 0; m_st[k] = 0;  m_pre[k] = 0;
            end
            rd_pend = 0;
        end else begin
            rd_pend = req && !wr;
            if (rd_pend) begin
                exp_rd   = m_read(addr);
                pend_tag = cur_tag;
            end
            for (int k = 0; k < 2; k++) m_step(k, req && wr, addr, wdata, tk[k]);
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_irq;
            e_irq = (m_ris[0] && m_ctl[0][5]) || (m_ris[1] && m_ctl[1][5]);
            n_chk++;
            if (irq !== e_irq) begin
                n_fail++;
                $display("FAIL R6 merged irq at cycle %0d: got %b expected %b", cyc, irq, e_irq);
            end
            if (rd_pend) begin
                n_chk++;
                if (rdata !== exp_rd) begin
                    n_fail++;
                    $display("FAIL R10 %s: got %h expected %h", pend_tag, rdata, exp_rd);
                end
            end
        end
    end

    task automatic finish_up();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            finish_up();
        end
    end

    task automatic wr_reg(logic [15:0] a, logic [31:0] d, string t);
        @(negedge clk);
        cur_tag = t; req = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        req = 0; wr = 0;
    endtask

    task automatic rd_reg(logic [15:0] a, string t);
        @(negedge clk);
        cur_tag = t; req = 1; wr = 0; addr = a;
        @(negedge clk);
        req = 0;
    endtask

    task automatic rd_exp(logic [15:0] a, logic [31:0] e, string t);
        rd_reg(a, t);
        n_chk++;
        if (rdata !== e) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", t, rdata, e);
        end
    endtask

    task automatic chk_irq(logic e, string t);
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", t, irq, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        rd_exp(16'h0008, 32'h20, "R3 reset control A");
        rd_exp(16'h0028, 32'h20, "R3 reset control B");
        chk_irq(1'b0, "R6 reset irq low");

        for (int i = 0; i < 8; i++)
            rd_exp(16'h0FE0 + 16'(4 * i), {24'h0, id_val(i)}, "R7 id byte");
        wr_reg(16'h0FE0, 32'hFFFF_FFFF, "R7 id write");
        rd_exp(16'h0FE0, 32'h04, "R7 id unchanged after write");

        rd_exp(16'h0F00, 32'h0, "R8 test control reads zero");
        rd_exp(16'h0F04, 32'h0, "R8 test output reads zero");
        rd_exp(16'h0040, 32'h0, "R8 offset 0x40 zero");
        rd_exp(16'h0800, 32'h0, "R8 mid window zero");
        rd_exp(16'h001C, 32'h0, "R2 unused slot zero");
        wr_reg(16'h0048, 32'hFF, "R8 write 0x48");
        wr_reg(16'h0068, 32'hFF, "R8 write 0x68");
        rd_exp(16'h0008, 32'h20, "R8 control A untouched");
        rd_exp(16'h0028, 32'h20, "R8 control B untouched");

        wr_reg(16'h1000, 32'h1234, "R1 aliased load");
        rd_exp(16'h0000, 32'h1234, "R1 load via alias");
        rd_exp(16'h0004, 32'h1234, "R2 load sets count");
        rd_exp(16'h0020, 32'h0, "R1 timer B limit separate");
        wr_reg(16'h0004, 32'h55, "R2 count write");
        rd_exp(16'h0004, 32'h1234, "R2 count read-only");
        wr_reg(16'h0018, 32'h77, "R2 shadow write");
        rd_exp(16'h0000, 32'h77, "R2 shadow sets limit");
        rd_exp(16'h0004, 32'h1234, "R2 shadow keeps count");

        // periodic A at full rate, B one-shot /16 with its tick held low
        tk = 2'b01;
        wr_reg(16'h0000, 32'd5, "R4 load A");
        wr_reg(16'h0008, 32'hE2, "R4 start A periodic");
        wr_reg(16'h0020, 32'd3, "R9 load B");
        wr_reg(16'h0028, 32'hA7, "R9 start B one-shot /16");
        repeat (20) @(negedge clk);
        rd_reg(16'h0004, "R4 periodic count");
        rd_exp(16'h0010, 32'h1, "R4 periodic expiry raw");
        rd_exp(16'h0024, 32'h3, "R9 B frozen without its tick");
        tk = 2'b11;
        repeat (90) @(negedge clk);
        rd_exp(16'h0030, 32'h1, "R5 one-shot raw");
        rd_exp(16'h0024, 32'h0, "R5 one-shot parked at zero");
        repeat (40) @(negedge clk);
        rd_exp(16'h0024, 32'h0, "R5 still parked");

        // merged interrupt with both pending
        wr_reg(16'h0008, 32'h62, "R6 stop A");
        wr_reg(16'h000C, 32'h0, "R6 ack A");
        chk_irq(1'b1, "R6 B alone holds irq");
        rd_exp(16'h0010, 32'h0, "R2 ack clears raw A");
        wr_reg(16'h002C, 32'h0, "R6 ack B");
        chk_irq(1'b0, "R6 both cleared");

        // masking
        wr_reg(16'h0020, 32'd2, "R6 load B");
        wr_reg(16'h0028, 32'h83, "R6 B one-shot no IE");
        repeat (10) @(negedge clk);
        rd_exp(16'h0030, 32'h1, "R6 raw set with IE clear");
        rd_exp(16'h0034, 32'h0, "R6 masked reads zero");
        chk_irq(1'b0, "R6 irq masked");
        wr_reg(16'h0028, 32'h23, "R6 enable IE");
        chk_irq(1'b1, "R6 IE unmasks pending raw");
        wr_reg(16'h002C, 32'h0, "R6 ack B again");

        // 16-bit free-running behind /256 with upper bits set
        wr_reg(16'h0000, 32'h0003_0002, "R4 narrow load");
        wr_reg(16'h0008, 32'hA8, "R4 narrow free-run /256");
        repeat (800) @(negedge clk);
        rd_exp(16'h0010, 32'h1, "R4 narrow expiry raw");
        rd_reg(16'h0004, "R4 narrow wrap count");
        rd_reg(16'h0014, "R4 narrow masked");

        // ack on the very expiry cycle
        wr_reg(16'h0008, 32'h20, "R11 stop A");
        wr_reg(16'h000C, 32'h0, "R11 clear A");
        wr_reg(16'h0000, 32'd3, "R11 load A");
        wr_reg(16'h0008, 32'hE2, "R11 start A");
        do @(negedge clk); while (!(m_st[0] == 1 && m_cnt[0] == 0));
        cur_tag = "R11 ack"; req = 1; wr = 1; addr = 16'h000C; wdata = 0;
        @(negedge clk);
        req = 0; wr = 0;
        chk_irq(1'b1, "R11 expiry beats ack");
        rd_exp(16'h0010, 32'h1, "R11 raw still set");

        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule